// File: doc/BRIEF.md
# Double-Buffered Converter Register Controller

This block sits between a two-wire serial receiver and a 10-bit voltage converter. The receiver hands it one pulse for each byte it acknowledges: the command byte, the low data byte and the high data byte. It also hands it a pulse for a STOP condition, a pulse when a transaction breaks off early, and a pulse with a one-bit flag when the shared broadcast address is acknowledged. The controller holds these bytes in an input stage. It moves them to the output latches only at an update event, so the analog side never sees a half-written code.

Two update policies are available. With the synchronous bit clear, the STOP that ends a write updates the outputs. With the bit set, STOP leaves the code and reference selection alone. A broadcast event with flag 1 then performs the update, so many converters on one bus can change together. A broadcast event with flag 0 clears every register, whatever the synchronous bit holds. The power-down request is applied at STOP and keeps all latched data.

Top module: `dac_reg_ctrl`

## Requirements
- R1: After reset the code output is 0, ref_internal is 0 (supply reference) and power_down is 0. The held synchronous bit is 0.
- R2: In the command byte, bit 0 is the synchronous-update enable, bit 1 requests power-down and bit 2 selects the internal reference. Bits 7..3 have no effect.
- R3: The low data byte supplies code bits 7..0. Bits 1..0 of the high data byte supply code bits 9..8, and high-byte bits 7..2 have no effect.
- R4: With the synchronous bit 0, a STOP copies the input code, reference select and power-down request to the outputs.
- R5: With the synchronous bit 1, a STOP leaves the code and ref_internal unchanged. A broadcast event with flag 1 then copies code, reference select and power-down to the outputs.
- R6: A broadcast event with flag 0 clears all input and output registers, whatever the synchronous bit holds.
- R7: A broadcast event with flag 1 has no effect when the synchronous bit is 0.
- R8: A power-down request reaches power_down only at a STOP or a synchronous transfer. Entering power-down keeps the output code.
- R9: A write that carries only a command byte updates the command register. The next update transfers the data input contents from before that write.
- R10: A data pair that is not completed is discarded and the command of that transaction is kept. This covers an abort or STOP after the low byte, and a high byte with no pending low byte.
- R11: Outputs change only in the cycle after a STOP or broadcast pulse, and hold otherwise.
- R12: The synchronous bit that governs a STOP is the one from the most recently accepted command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_stb | input | 1 | Command byte accepted |
| lo_stb | input | 1 | Low data byte accepted |
| hi_stb | input | 1 | High data byte accepted |
| rx_byte | input | 8 | Byte value for the strobes |
| xfer_abort | input | 1 | Transaction broke off before completion |
| stop_stb | input | 1 | STOP condition seen |
| bcast_stb | input | 1 | Broadcast address acknowledged |
| bcast_flag | input | 1 | Broadcast flag: 1 transfer, 0 clear |
| dac_code | output | 10 | Code presented to the converter |
| ref_internal | output | 1 | 1 selects the internal reference |
| power_down | output | 1 | Converter power-down |

## Verification
The bench sweeps every code and every command byte through complete writes. This catches swapped or shifted data bits, and ignored bits that leak into the outputs. It then targets the deferred-update cases. A design that updated on STOP while the synchronous bit was set would change the code early. One that honoured flag-1 broadcasts with the bit clear would pick up unfinished writes. A clear that spared the input stage would bring back stale data on the next STOP. A design that committed a lone low byte, or let a stale synchronous bit steer a STOP, would show a wrong code after the broken transaction.

// File: rtl/dac_reg_ctrl.sv
module dac_reg_ctrl #(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_stb,
  input  logic              lo_stb,
  input  logic              hi_stb,
  input  logic [7:0]        rx_byte,
  input  logic              xfer_abort,
  input  logic              stop_stb,
  input  logic              bcast_stb,
  input  logic              bcast_flag,
  output logic [CODE_W-1:0] dac_code,
  output logic              ref_internal,
  output logic              power_down
);
  localparam int HI_W = CODE_W - 8;

  logic              in_sy, in_sd, in_bg;
  logic [CODE_W-1:0] in_code;
  logic [7:0]        lo_hold;
  logic              lo_ok;

  logic do_clear, do_xfer;
  assign do_clear = bcast_stb & ~bcast_flag;
  assign do_xfer  = (bcast_stb & bcast_flag & in_sy) | (stop_stb & ~in_sy);

  always_ff @(posedge clk) begin
    if (!rst_n || do_clear) begin
      in_sy   <= 1'b0;
      in_sd   <= 1'b0;
      in_bg   <= 1'b0;
      in_code <= '0;
      lo_hold <= '0;
      lo_ok   <= 1'b0;
    end else begin
      if (cmd_stb) begin
        in_sy <= rx_byte[0];
        in_sd <= rx_byte[1];
        in_bg <= rx_byte[2];
        lo_ok <= 1'b0;
      end
      if (lo_stb) begin
        lo_hold <= rx_byte;
        lo_ok   <= 1'b1;
      end
      if (hi_stb) begin
        if (lo_ok) in_code <= {rx_byte[HI_W-1:0], lo_hold};
        lo_ok <= 1'b0;
      end
      if (stop_stb || xfer_abort) lo_ok <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || do_clear) begin
      dac_code     <= '0;
      ref_internal <= 1'b0;
      power_down   <= 1'b0;
    end else if (do_xfer) begin
      dac_code     <= in_code;
      ref_internal <= in_bg;
      power_down   <= in_sd;
    end else if (stop_stb) begin
      power_down   <= in_sd;
    end
  end
endmodule

module dac_reg_ctrl_chk #(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop_stb,
  input logic              bcast_stb,
  input logic              bcast_flag,
  input logic              in_sy,
  input logic              in_sd,
  input logic [CODE_W-1:0] dac_code,
  input logic              ref_internal,
  input logic              power_down
);
  a_r11_hold_between_events: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_stb && !bcast_stb) |=> ($stable(dac_code) && $stable(ref_internal) && $stable(power_down)));

  a_r6_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (bcast_stb && !bcast_flag) |=> (dac_code == '0 && !ref_internal && !power_down));

  a_r5_stop_deferred: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_stb && in_sy && !bcast_stb) |=> ($stable(dac_code) && $stable(ref_internal)));

  a_r7_sync_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bcast_stb && bcast_flag && !in_sy && !stop_stb) |=>
      ($stable(dac_code) && $stable(ref_internal) && $stable(power_down)));

  a_r8_sd_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_stb && !bcast_stb) |=> (power_down == $past(in_sd)));
endmodule

bind dac_reg_ctrl dac_reg_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_stb(stop_stb), .bcast_stb(bcast_stb),
  .bcast_flag(bcast_flag), .in_sy(in_sy), .in_sd(in_sd), .dac_code(dac_code),
  .ref_internal(ref_internal), .power_down(power_down)
);

// File: tb/dac_reg_ctrl_bench.sv
`timescale 1ns/1ps
module dac_reg_ctrl_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cmd_stb, lo_stb, hi_stb, xfer_abort, stop_stb, bcast_stb, bcast_flag;
  logic [7:0] rx_byte;
  logic [9:0] dac_code;
  logic ref_internal, power_down;

  dac_reg_ctrl u_dac_reg_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .lo_stb(lo_stb), .hi_stb(hi_stb),
    .rx_byte(rx_byte), .xfer_abort(xfer_abort), .stop_stb(stop_stb),
    .bcast_stb(bcast_stb), .bcast_flag(bcast_flag), .dac_code(dac_code),
    .ref_internal(ref_internal), .power_down(power_down)
  );

  int checks = 0;
  int errors = 0;

  logic       m_sy, m_sd, m_bg, m_lo_ok, m_out_bg, m_out_sd;
  logic [7:0] m_lo;
  logic [9:0] m_in, m_out;

  task automatic check(input string tag);
    checks++;
    if (dac_code !== m_out || ref_internal !== m_out_bg || power_down !== m_out_sd) begin
      errors++;
      $display("FAIL %s: code=%0d ref=%0b pd=%0b expected code=%0d ref=%0b pd=%0b",
               tag, dac_code, ref_internal, power_down, m_out, m_out_bg, m_out_sd);
    end
  endtask

  task automatic idle_all;
    cmd_stb = 0; lo_stb = 0; hi_stb = 0; xfer_abort = 0;
    stop_stb = 0; bcast_stb = 0; bcast_flag = 0; rx_byte = 0;
  endtask

  task automatic send_cmd(input logic [7:0] b);
    @(negedge clk); cmd_stb = 1; rx_byte = b;
    @(negedge clk); cmd_stb = 0;
    m_sy = b[0]; m_sd = b[1]; m_bg = b[2]; m_lo_ok = 0;
  endtask

  task automatic send_lo(input logic [7:0] b);
    @(negedge clk); lo_stb = 1; rx_byte = b;
    @(negedge clk); lo_stb = 0;
    m_lo = b; m_lo_ok = 1;
  endtask

  task automatic send_hi(input logic [7:0] b);
    @(negedge clk); hi_stb = 1; rx_byte = b;
    @(negedge clk); hi_stb = 0;
    if (m_lo_ok) m_in = {b[1:0], m_lo};
    m_lo_ok = 0;
  endtask

  task automatic send_abort;
    @(negedge clk); xfer_abort = 1;
    @(negedge clk); xfer_abort = 0;
    m_lo_ok = 0;
  endtask

  task automatic send_stop;
    @(negedge clk); stop_stb = 1;
    @(negedge clk); stop_stb = 0;
    m_lo_ok = 0;
    m_out_sd = m_sd;
    if (!m_sy) begin m_out = m_in; m_out_bg = m_bg; end
  endtask

  task automatic send_bcast(input logic f);
    @(negedge clk); bcast_stb = 1; bcast_flag = f;
    @(negedge clk); bcast_stb = 0; bcast_flag = 0;
    if (!f) begin
      m_sy = 0; m_sd = 0; m_bg = 0; m_lo_ok = 0; m_lo = 0; m_in = 0;
      m_out = 0; m_out_bg = 0; m_out_sd = 0;
    end else if (m_sy) begin
      m_out = m_in; m_out_bg = m_bg; m_out_sd = m_sd;
    end
  endtask

  task automatic write_word(input logic [7:0] c, input logic [9:0] v, input logic [5:0] junk);
    send_cmd(c); send_lo(v[7:0]); send_hi({junk, v[9:8]});
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle_all();
    rst_n = 0;
    m_sy = 0; m_sd = 0; m_bg = 0; m_lo_ok = 0; m_lo = 0; m_in = 0;
    m_out = 0; m_out_bg = 0; m_out_sd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset");

    for (int k = 0; k < 1024; k++) begin
      write_word(8'h00, k[9:0], k[5:0] ^ 6'h2A);
      check("R11 before stop");
      send_stop();
      check("R3 R4 code sweep");
    end

    for (int c = 0; c < 256; c++) begin
      write_word(c[7:0], 10'(c * 3 + 7), 6'h3F);
      check("R8 R11 no change before stop");
      send_stop();
      check("R2 command sweep");
      if (c[0]) begin
        send_bcast(1'b1);
        check("R5 sync transfer");
      end
    end

    write_word(8'h00, 10'h255, 6'h15); send_stop();
    send_cmd(8'h04); send_stop();
    check("R9 command only write");

    send_cmd(8'h00); send_lo(8'hAA); send_abort(); send_hi(8'h03); send_stop();
    check("R10 abort after low byte");
    send_cmd(8'h00); send_lo(8'h11); send_stop();
    send_cmd(8'h00); send_hi(8'h01); send_stop();
    check("R10 lone high byte");

    write_word(8'h01, 10'h3C1, 6'h00); send_stop();
    check("R5 stop deferred");
    send_bcast(1'b1);
    check("R5 broadcast transfer");

    write_word(8'h01, 10'h0F0, 6'h00); send_stop();
    send_cmd(8'h00); send_stop();
    check("R12 latest sync bit governs stop");

    write_word(8'h04, 10'h123, 6'h00);
    send_bcast(1'b1);
    check("R7 broadcast ignored without sync bit");
    send_stop();
    check("R7 stop after ignored broadcast");

    send_cmd(8'h06); send_stop();
    check("R8 power-down keeps code");
    send_cmd(8'h03); send_stop();
    check("R8 power-down at stop with sync bit");

    write_word(8'h05, 10'h2EE, 6'h00); send_stop();
    send_bcast(1'b0);
    check("R6 clear outputs");
    send_cmd(8'h00); send_stop();
    check("R6 clear input stage");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule